// File: doc/BRIEF.md
# Vertex Shader Result Write-Back Unit

This block stores the results of one vertex program instruction. Each retiring instruction brings two four-component results, one from the multiply-accumulate unit and one from the inverse-logic unit. The block writes them into a twelve-entry temporary file or into an eleven-entry output file. Per-component masks decide which components change. Each component is 32 bits wide, and a four-component value is packed as X in bits 127:96, Y in 95:64, Z in 63:32 and W in 31:0.

The output file uses a sparse index space. Index 0 is the position. Indices 3 to 12 are the two front colors, fog, point size, the two back colors and four texture coordinate sets. Indices 1, 2 and 13 to 255 hold no register. The position register can also be read as temporary 12.

Two combinational read ports give access to both files. One read port covers the temporary file and the other covers the output file. A one-cycle done pulse marks the retirement of the instruction that carries the end-of-program bit.

Top module: `vsh_writeback`

## Requirements
- R1: While reset is asserted and after it is released, every output register reads X=Y=Z=0x00000000 and W=0x3F800000, every temporary reads zero, and `done` is low.
- R2: In every write mask, bit 3 selects X, bit 2 selects Y, bit 1 selects Z and bit 0 selects W. A component changes only where its mask bit is 1, and all other components keep their value.
- R3: When `wb_valid`=1 and `dst_sel`=0, temporary `tmp_idx` takes `mac_res` in the components set in `mac_mask` and `ilu_res` in the components set in `ilu_mask`. The output file does not change.
- R4: When a component is set in both `mac_mask` and `ilu_mask`, the temporary takes the `mac_res` value for that component.
- R5: When `wb_valid`=1 and `dst_sel`=1, output register `out_idx` takes the result chosen by `dst_mux` (0 = multiply-accumulate, 1 = inverse-logic) in the components set in `out_mask`. The temporary file does not change.
- R6: Only output indices 0 and 3 to 12 hold registers. A write to any other output index changes nothing, and a read of such an index returns zero.
- R7: A read of temporary index 12 returns the position output register, including a write made at the previous clock edge. Temporary indices 13 to 15 read zero, and temporary writes to indices 12 to 15 are dropped.
- R8: `done` is high for exactly the cycle after a clock edge at which `wb_valid`=1 and `eop`=1. When `wb_valid`=0, neither file changes.
- R9: Writes take effect at the rising clock edge. Both read ports are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_valid | input | 1 | An instruction retires this cycle |
| dst_sel | input | 1 | 0 = temporary file, 1 = output file |
| dst_mux | input | 1 | Source for the output write: 0 = multiply-accumulate, 1 = inverse-logic |
| tmp_idx | input | 4 | Destination temporary index |
| out_idx | input | 8 | Destination output index |
| mac_mask | input | 4 | Multiply-accumulate temporary write mask |
| ilu_mask | input | 4 | Inverse-logic temporary write mask |
| out_mask | input | 4 | Output write mask |
| eop | input | 1 | End-of-program marker |
| mac_res | input | 128 | Multiply-accumulate result |
| ilu_res | input | 128 | Inverse-logic result |
| rd_tmp_idx | input | 4 | Temporary read index |
| rd_tmp_data | output | 128 | Temporary read data |
| rd_out_idx | input | 8 | Output read index |
| rd_out_data | output | 128 | Output read data |
| done | output | 1 | Program-retired pulse |

## Verification
The in-line properties check the following on every cycle:
- the timing of the done pulse;
- that idle cycles and writes to undefined output indices leave both files untouched;
- that an output write leaves the temporary file unchanged;
- the multiply-accumulate priority on the X component;
- that a position write lands in the register that temporary 12 mirrors.

The bench's scenarios are needed for the rest. They show the reset values, the mask bit order on every component and the zero reads of unmapped indices. They also show that a temporary 12 read sees the new position on the next cycle. A reference model compared on every clock covers long random mixes of both destination kinds.

// File: rtl/vsh_writeback.sv
module vsh_writeback #(
  parameter int CW       = 32,
  parameter int NTMP     = 12,
  parameter int OUT_LAST = 12,
  parameter logic [31:0] WONE = 32'h3F80_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wb_valid,
  input  logic            dst_sel,
  input  logic            dst_mux,
  input  logic [3:0]      tmp_idx,
  input  logic [7:0]      out_idx,
  input  logic [3:0]      mac_mask,
  input  logic [3:0]      ilu_mask,
  input  logic [3:0]      out_mask,
  input  logic            eop,
  input  logic [4*CW-1:0] mac_res,
  input  logic [4*CW-1:0] ilu_res,
  input  logic [3:0]      rd_tmp_idx,
  output logic [4*CW-1:0] rd_tmp_data,
  input  logic [7:0]      rd_out_idx,
  output logic [4*CW-1:0] rd_out_data,
  output logic            done
);
  localparam int RW    = 4 * CW;
  localparam int NSLOT = OUT_LAST - 1;
  localparam logic [RW-1:0] ORST = {{(3*CW){1'b0}}, WONE[CW-1:0]};

  logic [NTMP-1:0][RW-1:0]  treg;
  logic [NSLOT-1:0][RW-1:0] oreg;

  function automatic logic out_ok(input logic [7:0] i);
    return (i == 8'd0) || (i >= 8'd3 && i <= 8'(OUT_LAST));
  endfunction

  function automatic logic [7:0] out_slot(input logic [7:0] i);
    return (i == 8'd0) ? 8'd0 : i - 8'd2;
  endfunction

  wire wr_tmp = wb_valid & ~dst_sel;
  wire wr_out = wb_valid & dst_sel;
  wire [RW-1:0] out_src = dst_mux ? ilu_res : mac_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      treg <= '0;
    end else if (wr_tmp) begin
      for (int t = 0; t < NTMP; t++) begin
        if (tmp_idx == 4'(t)) begin
          for (int k = 0; k < 4; k++) begin
            if (mac_mask[k])      treg[t][k*CW +: CW] <= mac_res[k*CW +: CW];
            else if (ilu_mask[k]) treg[t][k*CW +: CW] <= ilu_res[k*CW +: CW];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) oreg[s] <= ORST;
    end else if (wr_out && out_ok(out_idx)) begin
      for (int s = 0; s < NSLOT; s++) begin
        if (out_slot(out_idx) == 8'(s)) begin
          for (int k = 0; k < 4; k++)
            if (out_mask[k]) oreg[s][k*CW +: CW] <= out_src[k*CW +: CW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= wb_valid & eop;
  end

  always_comb begin
    rd_tmp_data = '0;
    if (rd_tmp_idx == 4'(NTMP)) rd_tmp_data = oreg[0];
    for (int t = 0; t < NTMP; t++)
      if (rd_tmp_idx == 4'(t)) rd_tmp_data = treg[t];
  end

  always_comb begin
    rd_out_data = '0;
    for (int s = 0; s < NSLOT; s++)
      if (out_ok(rd_out_idx) && out_slot(rd_out_idx) == 8'(s)) rd_out_data = oreg[s];
  end

  p_done_after_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wb_valid & eop));
  p_eop_gives_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid & eop) |=> done);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |=> ($stable(treg) && $stable(oreg)));
  p_out_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && dst_sel && !out_ok(out_idx)) |=> $stable(oreg));
  p_tmp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && dst_sel) |=> $stable(treg));
  p_mac_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !dst_sel && tmp_idx < 4'(NTMP) && mac_mask[3] && ilu_mask[3])
    |=> (treg[$past(tmp_idx)][RW-1 -: CW] == $past(mac_res[RW-1 -: CW])));
  p_pos_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && dst_sel && out_idx == 8'd0 && out_mask[3])
    |=> (oreg[0][RW-1 -: CW] == $past(out_src[RW-1 -: CW])));
endmodule

// File: tb/vsh_writeback_tb.sv
module vsh_writeback_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wb_valid = 0, dst_sel = 0, dst_mux = 0, eop = 0;
  logic [3:0] tmp_idx = 0, mac_mask = 0, ilu_mask = 0, out_mask = 0, rd_tmp_idx = 0;
  logic [7:0] out_idx = 0, rd_out_idx = 0;
  logic [127:0] mac_res = 0, ilu_res = 0, rd_tmp_data, rd_out_data;
  logic done;

  int checks = 0, errors = 0;
  string tag = "R1";
  logic [127:0] mtmp [12];
  logic [127:0] mout [13];
  logic mdone = 0;

  always #10 clk = ~clk;

  vsh_writeback u_dut (.clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .dst_sel(dst_sel),
    .dst_mux(dst_mux), .tmp_idx(tmp_idx), .out_idx(out_idx), .mac_mask(mac_mask),
    .ilu_mask(ilu_mask), .out_mask(out_mask), .eop(eop), .mac_res(mac_res),
    .ilu_res(ilu_res), .rd_tmp_idx(rd_tmp_idx), .rd_tmp_data(rd_tmp_data),
    .rd_out_idx(rd_out_idx), .rd_out_data(rd_out_data), .done(done));

  function automatic bit oidx_ok(int i);
    return i == 0 || (i >= 3 && i <= 12);
  endfunction

  function automatic logic [127:0] m_rt(int i);
    if (i < 12) return mtmp[i];
    if (i == 12) return mout[0];
    return '0;
  endfunction

  function automatic logic [127:0] m_ro(int i);
    return oidx_ok(i) ? mout[i] : '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mtmp[i]) mtmp[i] = '0;
      foreach (mout[i]) mout[i] = {96'd0, 32'h3F80_0000};
      mdone = 0;
    end else begin
      if (wb_valid && !dst_sel && tmp_idx < 12) begin
        for (int c = 0; c < 4; c++) begin
          if (mac_mask[c]) mtmp[tmp_idx][c*32 +: 32] = mac_res[c*32 +: 32];
          else if (ilu_mask[c]) mtmp[tmp_idx][c*32 +: 32] = ilu_res[c*32 +: 32];
        end
      end
      if (wb_valid && dst_sel && oidx_ok(int'(out_idx))) begin
        for (int c = 0; c < 4; c++)
          if (out_mask[c]) mout[out_idx][c*32 +: 32] = (dst_mux ? ilu_res[c*32 +: 32] : mac_res[c*32 +: 32]);
      end
      mdone = wb_valid && eop;
    end
  end

  task automatic chk(string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cycle_cmp();
    chk("done", {127'd0, done}, {127'd0, mdone});
    chk("rd_tmp", rd_tmp_data, m_rt(int'(rd_tmp_idx)));
    chk("rd_out", rd_out_data, m_ro(int'(rd_out_idx)));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cycle_cmp();
  endtask

  task automatic dump();
    wb_valid = 0; eop = 0;
    for (int i = 0; i < 16; i++) begin
      rd_tmp_idx = 4'(i); #1;
      chk("tmp dump", rd_tmp_data, m_rt(i));
    end
    for (int i = 0; i < 20; i++) begin
      rd_out_idx = 8'(i); #1;
      chk("out dump", rd_out_data, m_ro(i));
    end
    rd_out_idx = 8'd255; #1;
    chk("out dump 255", rd_out_data, '0);
  endtask

  task automatic issue(bit sel, bit mux, int ti, int oi, logic [3:0] mm, logic [3:0] im,
                       logic [3:0] om, bit e, logic [127:0] mr, logic [127:0] ir);
    wb_valid = 1; dst_sel = sel; dst_mux = mux; tmp_idx = 4'(ti); out_idx = 8'(oi);
    mac_mask = mm; ilu_mask = im; out_mask = om; eop = e; mac_res = mr; ilu_res = ir;
    step();
    wb_valid = 0; eop = 0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1"; dump();
    chk("done in reset", {127'd0, done}, '0);
    rst_n = 1;
    step(); dump();

    tag = "R2";
    issue(0, 0, 2, 0, 4'b1000, 4'b0000, 4'b0000, 0, {32'hAAAA0001, 32'hAAAA0002, 32'hAAAA0003, 32'hAAAA0004}, '0);
    rd_tmp_idx = 2; #1; chk("X only", rd_tmp_data, {32'hAAAA0001, 96'd0});
    issue(0, 0, 2, 0, 4'b0001, 4'b0000, 4'b0000, 0, {32'h1, 32'h2, 32'h3, 32'h4}, '0);
    #1; chk("W only", rd_tmp_data, {32'hAAAA0001, 64'd0, 32'h4});

    tag = "R3";
    issue(0, 0, 5, 0, 4'b1100, 4'b0011, 4'b1111, 0, {4{32'h11111111}}, {4{32'h22222222}});
    rd_tmp_idx = 5; #1; chk("split", rd_tmp_data, {32'h11111111, 32'h11111111, 32'h22222222, 32'h22222222});

    tag = "R4";
    issue(0, 0, 7, 0, 4'b1111, 4'b1111, 4'b0000, 0, {4{32'h33333333}}, {4{32'h44444444}});
    rd_tmp_idx = 7; #1; chk("mac wins", rd_tmp_data, {4{32'h33333333}});

    tag = "R5";
    issue(1, 1, 3, 9, 4'b1111, 4'b1111, 4'b0110, 0, {4{32'h55555555}}, {4{32'h66666666}});
    rd_out_idx = 9; #1; chk("ilu to out", rd_out_data, {32'h0, 32'h66666666, 32'h66666666, 32'h3F800000});
    dump();

    tag = "R6";
    issue(1, 0, 0, 1, 0, 0, 4'b1111, 0, rnd128(), rnd128());
    issue(1, 0, 0, 2, 0, 0, 4'b1111, 0, rnd128(), rnd128());
    issue(1, 0, 0, 13, 0, 0, 4'b1111, 0, rnd128(), rnd128());
    issue(1, 1, 0, 200, 0, 0, 4'b1111, 0, rnd128(), rnd128());
    dump();

    tag = "R7";
    rd_tmp_idx = 12;
    issue(1, 0, 0, 0, 0, 0, 4'b1010, 0, {32'h77777777, 32'h88888888, 32'h99999999, 32'hABABABAB}, '0);
    #1; chk("mirror next cycle", rd_tmp_data, {32'h77777777, 32'h0, 32'h99999999, 32'h3F800000});
    issue(0, 0, 12, 0, 4'b1111, 4'b1111, 0, 0, rnd128(), rnd128());
    issue(0, 0, 14, 0, 4'b1111, 4'b1111, 0, 0, rnd128(), rnd128());
    dump();

    tag = "R8";
    issue(0, 0, 1, 0, 4'b1111, 0, 0, 1, rnd128(), rnd128());
    wb_valid = 0; mac_mask = 4'b1111; out_mask = 4'b1111; mac_res = rnd128();
    step(); step();
    dump();

    tag = "R9";
    for (int n = 0; n < 400; n++) begin
      wb_valid = ($urandom_range(0, 3) != 0); dst_sel = $urandom_range(0, 1);
      dst_mux = $urandom_range(0, 1); tmp_idx = 4'($urandom_range(0, 15));
      out_idx = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'($urandom_range(0, 13));
      mac_mask = 4'($urandom); ilu_mask = 4'($urandom); out_mask = 4'($urandom);
      eop = ($urandom_range(0, 7) == 0); mac_res = rnd128(); ilu_res = rnd128();
      rd_tmp_idx = 4'($urandom); rd_out_idx = 8'($urandom_range(0, 15));
      step();
    end
    dump();
    finish_run();
  end
endmodule